// File: doc/BRIEF.md
# Three-Group Prioritized Interrupt Controller

This block gathers level-sensitive interrupt requests from three classes of source: a small critical class of three inputs (an external line, a timer and a wake event), a main class, and a peripheral class. Each source can be masked on its own. Every class is arbitrated separately. The result is kept in one encoded status word, which holds one index field and one valid bit per class. Firmware reads that word and services the first valid field, taking critical first, then main, then peripheral. A single line to the processor is raised whenever any field holds a request.

Any peripheral source can be raised to medium or high priority. A raised source still appears in the peripheral field. It also places a reserved code in the main field (medium) or in the critical field (high), but only when no real source of that class is pending. A handler for the upper class can therefore find out that it must look at the peripheral field. Software programs the masks and the boost settings through a flat register port: writes are clocked and reads are combinational.

Top module: `pic_top`

## Requirements
- R1: After reset, all three mask registers read as all ones. The boost register reads zero. The status word reads 0x001F1F1F, which means every field holds 31 and every valid bit is 0. irqOut is low.
- R2: The critical field (status bits 20:16) holds the lowest index among the pending, unmasked critical sources. Critical mask bit i (address 0) blocks critical source i.
- R3: The main field (bits 12:8) holds the lowest index among the pending, unmasked main sources. Main mask bit i (address 1) blocks main source i.
- R4: The peripheral field (bits 4:0) is chosen from the pending, unmasked peripheral sources. Any high-boosted source beats any medium one, and any medium one beats any normal one. Within a boost class, the lowest index wins. Peripheral mask bit i is at address 2.
- R5: Boost register bits 2i+1:2i (address 3) set the class of peripheral i: 00 is normal, 01 is medium, 1x is high. When no critical source is pending and unmasked, but a high-boosted peripheral source is, the critical field holds the reserved code 30.
- R6: When no main source is pending and unmasked, but a medium-boosted peripheral source is, the main field holds the reserved code 30.
- R7: A masked source never reaches any status field and never raises irqOut.
- R8: The valid bits sit at bit 26 (critical), bit 25 (main) and bit 24 (peripheral). A class with nothing to report has its field at 31 and its valid bit at 0. Otherwise the valid bit is 1.
- R9: irqOut is high exactly when at least one valid bit in the status word is set.
- R10: The status word (address 4) and irqOut change only at a clock edge. They reflect the requests and settings present at the previous edge. Mask and boost registers read back what was last written.
- R11: A write to address 4 or above changes no register. Reads of addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Combinational read data |
| critReq | input | 3 | Critical class requests |
| mainReq | input | 17 | Main class requests |
| periReq | input | 16 | Peripheral class requests |
| irqOut | output | 1 | Interrupt line to the processor |

## Verification
A wrong mask or boost bit shows up as a wrong index or a wrong reserved code in the status word, one edge after the request pattern that exposes it. Readback of the configuration registers catches a corrupted setting at once. The sweep pairs random masks, boost classes and request densities with an arithmetic model of the three-class selection. This way, errors in class precedence, in the lowest-index rule and in the handling of the reserved code all surface as a field mismatch within a single cycle. Directed cases pin down the one-edge latency and the dead addresses.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CRIT_MASK = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MAIN_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_PERI_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PERI_PRIO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS    = 3'd4;

  localparam int PERI_LSB   = 0;
  localparam int MAIN_LSB   = 8;
  localparam int CRIT_LSB   = 16;
  localparam int PERI_V_BIT = 24;
  localparam int MAIN_V_BIT = 25;
  localparam int CRIT_V_BIT = 26;

  typedef enum logic [2:0] {
    SEL_CRIT_MASK,
    SEL_MAIN_MASK,
    SEL_PERI_MASK,
    SEL_PERI_PRIO,
    SEL_STATUS,
    SEL_NONE
  } rd_sel_e;

  typedef struct packed {
    logic    wrCritMask;
    logic    wrMainMask;
    logic    wrPeriMask;
    logic    wrPeriPrio;
    rd_sel_e rdSel;
  } pic_strobe_t;
endpackage

// File: rtl/pic_prienc.sv
module pic_prienc #(
  parameter int N = 8,
  parameter int W = 5
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         hit
);
  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = W'(i);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output pic_strobe_t       strobe
);
  always_comb begin
    strobe.wrCritMask = wrEn && (wrAddr == ADDR_CRIT_MASK);
    strobe.wrMainMask = wrEn && (wrAddr == ADDR_MAIN_MASK);
    strobe.wrPeriMask = wrEn && (wrAddr == ADDR_PERI_MASK);
    strobe.wrPeriPrio = wrEn && (wrAddr == ADDR_PERI_PRIO);
    unique case (rdAddr)
      ADDR_CRIT_MASK: strobe.rdSel = SEL_CRIT_MASK;
      ADDR_MAIN_MASK: strobe.rdSel = SEL_MAIN_MASK;
      ADDR_PERI_MASK: strobe.rdSel = SEL_PERI_MASK;
      ADDR_PERI_PRIO: strobe.rdSel = SEL_PERI_PRIO;
      ADDR_STATUS:    strobe.rdSel = SEL_STATUS;
      default:        strobe.rdSel = SEL_NONE;
    endcase
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCritMask, strobe.wrMainMask, strobe.wrPeriMask, strobe.wrPeriPrio})); // R11
  AST_DEAD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr >= ADDR_STATUS) |->
      !(strobe.wrCritMask || strobe.wrMainMask || strobe.wrPeriMask || strobe.wrPeriPrio)); // R11
endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_CRIT = 3,
  parameter int NUM_MAIN = 17,
  parameter int NUM_PERI = 16,
  parameter int FIELD_W  = 5,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  pic_strobe_t         strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_CRIT-1:0] critReq,
  input  logic [NUM_MAIN-1:0] mainReq,
  input  logic [NUM_PERI-1:0] periReq,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);
  localparam int PRIO_W = 2 * NUM_PERI;
  localparam logic [FIELD_W-1:0] CODE_NONE  = '1;
  localparam logic [FIELD_W-1:0] CODE_BOOST = CODE_NONE - 1'b1;

  logic [NUM_CRIT-1:0] critMaskQ;
  logic [NUM_MAIN-1:0] mainMaskQ;
  logic [NUM_PERI-1:0] periMaskQ;
  logic [PRIO_W-1:0]   periPrioQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      critMaskQ <= '1;
      mainMaskQ <= '1;
      periMaskQ <= '1;
      periPrioQ <= '0;
    end else begin
      if (strobe.wrCritMask) critMaskQ <= wrData[NUM_CRIT-1:0];
      if (strobe.wrMainMask) mainMaskQ <= wrData[NUM_MAIN-1:0];
      if (strobe.wrPeriMask) periMaskQ <= wrData[NUM_PERI-1:0];
      if (strobe.wrPeriPrio) periPrioQ <= wrData[PRIO_W-1:0];
    end
  end

  logic [NUM_CRIT-1:0] critLive;
  logic [NUM_MAIN-1:0] mainLive;
  logic [NUM_PERI-1:0] periLive, periHigh, periMed, periNorm;

  assign critLive = critReq & ~critMaskQ;
  assign mainLive = mainReq & ~mainMaskQ;
  assign periLive = periReq & ~periMaskQ;

  for (genvar g = 0; g < NUM_PERI; g++) begin : gSplit
    assign periHigh[g] = periLive[g] &  periPrioQ[2*g+1];
    assign periMed[g]  = periLive[g] & ~periPrioQ[2*g+1] &  periPrioQ[2*g];
    assign periNorm[g] = periLive[g] & ~periPrioQ[2*g+1] & ~periPrioQ[2*g];
  end

  logic [FIELD_W-1:0] critIdx, mainIdx, highIdx, medIdx, normIdx;
  logic               critHit, mainHit, highHit, medHit, normHit;

  pic_prienc #(.N(NUM_CRIT), .W(FIELD_W)) uCritEnc (.req(critLive), .idx(critIdx), .hit(critHit));
  pic_prienc #(.N(NUM_MAIN), .W(FIELD_W)) uMainEnc (.req(mainLive), .idx(mainIdx), .hit(mainHit));
  pic_prienc #(.N(NUM_PERI), .W(FIELD_W)) uHighEnc (.req(periHigh), .idx(highIdx), .hit(highHit));
  pic_prienc #(.N(NUM_PERI), .W(FIELD_W)) uMedEnc  (.req(periMed),  .idx(medIdx),  .hit(medHit));
  pic_prienc #(.N(NUM_PERI), .W(FIELD_W)) uNormEnc (.req(periNorm), .idx(normIdx), .hit(normHit));

  logic [FIELD_W-1:0] critNext, mainNext, periNext;
  logic               critVNext, mainVNext, periVNext;

  always_comb begin
    critVNext = critHit | highHit;
    mainVNext = mainHit | medHit;
    periVNext = highHit | medHit | normHit;
    critNext  = critHit ? critIdx : (highHit ? CODE_BOOST : CODE_NONE);
    mainNext  = mainHit ? mainIdx : (medHit ? CODE_BOOST : CODE_NONE);
    if (highHit)      periNext = highIdx;
    else if (medHit)  periNext = medIdx;
    else if (normHit) periNext = normIdx;
    else              periNext = CODE_NONE;
  end

  logic [FIELD_W-1:0] critFieldQ, mainFieldQ, periFieldQ;
  logic               critValidQ, mainValidQ, periValidQ, irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      critFieldQ <= CODE_NONE;
      mainFieldQ <= CODE_NONE;
      periFieldQ <= CODE_NONE;
      critValidQ <= 1'b0;
      mainValidQ <= 1'b0;
      periValidQ <= 1'b0;
      irqQ       <= 1'b0;
    end else begin
      critFieldQ <= critNext;
      mainFieldQ <= mainNext;
      periFieldQ <= periNext;
      critValidQ <= critVNext;
      mainValidQ <= mainVNext;
      periValidQ <= periVNext;
      irqQ       <= critVNext | mainVNext | periVNext;
    end
  end

  assign irqOut = irqQ;

  logic [DATA_W-1:0] statusWord;
  always_comb begin
    statusWord = '0;
    statusWord[PERI_LSB +: FIELD_W] = periFieldQ;
    statusWord[MAIN_LSB +: FIELD_W] = mainFieldQ;
    statusWord[CRIT_LSB +: FIELD_W] = critFieldQ;
    statusWord[PERI_V_BIT] = periValidQ;
    statusWord[MAIN_V_BIT] = mainValidQ;
    statusWord[CRIT_V_BIT] = critValidQ;
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      SEL_CRIT_MASK: rdData[NUM_CRIT-1:0] = critMaskQ;
      SEL_MAIN_MASK: rdData[NUM_MAIN-1:0] = mainMaskQ;
      SEL_PERI_MASK: rdData[NUM_PERI-1:0] = periMaskQ;
      SEL_PERI_PRIO: rdData[PRIO_W-1:0]   = periPrioQ;
      SEL_STATUS:    rdData = statusWord;
      default:       rdData = '0;
    endcase
  end

  AST_EMPTY_CRIT: assert property (@(posedge clk) disable iff (!rstN)
    !critValidQ |-> critFieldQ == CODE_NONE); // R8
  AST_EMPTY_PERI: assert property (@(posedge clk) disable iff (!rstN)
    !periValidQ |-> periFieldQ == CODE_NONE); // R8
  AST_CRIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    critValidQ |-> (critFieldQ < FIELD_W'(NUM_CRIT) || critFieldQ == CODE_BOOST)); // R2
  AST_HIGH_BACKED: assert property (@(posedge clk) disable iff (!rstN)
    (critValidQ && critFieldQ == CODE_BOOST) |-> periValidQ); // R5
  AST_MED_BACKED: assert property (@(posedge clk) disable iff (!rstN)
    (mainValidQ && mainFieldQ == CODE_BOOST) |-> periValidQ); // R6
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    periValidQ |-> ((($past(periMaskQ) >> periFieldQ) & NUM_PERI'(1)) == '0)); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (|(critReq & ~critMaskQ)) |=> irqOut); // R9
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_CRIT = 3,
  parameter int NUM_MAIN = 17,
  parameter int NUM_PERI = 16,
  parameter int FIELD_W  = 5,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic [NUM_CRIT-1:0] critReq,
  input  logic [NUM_MAIN-1:0] mainReq,
  input  logic [NUM_PERI-1:0] periReq,
  output logic                irqOut
);
  pic_strobe_t strobe;

  pic_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .strobe(strobe)
  );

  pic_datapath #(
    .NUM_CRIT(NUM_CRIT), .NUM_MAIN(NUM_MAIN), .NUM_PERI(NUM_PERI),
    .FIELD_W(FIELD_W), .DATA_W(DATA_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .critReq(critReq), .mainReq(mainReq), .periReq(periReq),
    .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_pic_top.sv
module tb_pic_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [2:0]  critReq = '0;
  logic [16:0] mainReq = '0;
  logic [15:0] periReq = '0;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  pic_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .critReq(critReq), .mainReq(mainReq),
    .periReq(periReq), .irqOut(irqOut)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] cm, input logic [16:0] mm,
      input logic [15:0] pm, input logic [31:0] pp, input logic [2:0] cr,
      input logic [16:0] mr, input logic [15:0] pr);
    logic [4:0] cf, mf, pf, hi, me, no;
    logic [31:0] s;
    cf = 5'd31; mf = 5'd31; hi = 5'd31; me = 5'd31; no = 5'd31;
    for (int i = 2; i >= 0; i--) if (cr[i] && !cm[i]) cf = 5'(i);
    for (int i = 16; i >= 0; i--) if (mr[i] && !mm[i]) mf = 5'(i);
    for (int i = 15; i >= 0; i--) begin
      if (pr[i] && !pm[i]) begin
        if (pp[2*i+1]) hi = 5'(i);
        else if (pp[2*i]) me = 5'(i);
        else no = 5'(i);
      end
    end
    pf = (hi != 5'd31) ? hi : (me != 5'd31) ? me : no;
    if (cf == 5'd31 && hi != 5'd31) cf = 5'd30;
    if (mf == 5'd31 && me != 5'd31) mf = 5'd30;
    s = '0;
    s[4:0] = pf; s[12:8] = mf; s[20:16] = cf;
    s[24] = (pf != 5'd31); s[25] = (mf != 5'd31); s[26] = (cf != 5'd31);
    return s;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, s0;
    tick(); tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    rd(3'd0, d); chk("R1 critMask", d, 32'h7);
    rd(3'd1, d); chk("R1 mainMask", d, 32'h1FFFF);
    rd(3'd2, d); chk("R1 periMask", d, 32'hFFFF);
    rd(3'd3, d); chk("R1 boost", d, 32'h0);
    rd(3'd4, d); chk("R1 status", d, 32'h001F1F1F);
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R7 requests while all masked stay invisible
    critReq = '1; mainReq = '1; periReq = '1;
    tick(); tick();
    rd(3'd4, d); chk("R7 all masked status", d, 32'h001F1F1F);
    chk("R7 all masked irq", {31'b0, irqOut}, 32'h0);
    critReq = '0; mainReq = '0; periReq = '0;

    // R5 R6 R4 directed boost
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
    wr(3'd3, 32'h0004_0800);
    rd(3'd3, d); chk("R10 boost readback", d, 32'h0004_0800);
    periReq = 16'h0224;
    tick();
    rd(3'd4, d); chk("R5 R6 R4 boosted codes", d, 32'h071E1E05);
    mainReq = 17'h00200; critReq = 3'b010;
    tick();
    rd(3'd4, d); chk("R2 R3 real sources beat reserved", d, 32'h07010905);
    critReq = '0; mainReq = '0; periReq = '0;
    wr(3'd3, 32'h0);
    tick();

    // R10 latency: status moves only at the edge
    rd(3'd4, s0); chk("R8 idle status", s0, 32'h001F1F1F);
    critReq = 3'b100;
    rd(3'd4, d); chk("R10 before edge", d, 32'h001F1F1F);
    tick();
    rd(3'd4, d); chk("R10 after edge", d, 32'h04021F1F);
    chk("R9 irq after edge", {31'b0, irqOut}, 32'h1);
    critReq = '0;
    tick();

    // R11 dead addresses
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R11 critMask untouched", d, 32'h0);
    rd(3'd2, d); chk("R11 periMask untouched", d, 32'h0);
    rd(3'd3, d); chk("R11 boost untouched", d, 32'h0);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R11 dead read", d, 32'h0);
    end

    // Sweep: R2 R3 R4 R5 R6 R7 R8 R9
    for (int it = 0; it < 1500; it++) begin
      logic [2:0]  cm, cr;
      logic [16:0] mm, mr;
      logic [15:0] pm, pr;
      logic [31:0] pp, e;
      cm = 3'($urandom); mm = 17'($urandom); pm = 16'($urandom);
      pp = $urandom;
      cr = 3'($urandom); mr = 17'($urandom); pr = 16'($urandom);
      if (it % 4 == 1) begin cr = cr & 3'($urandom); mr = mr & 17'($urandom) & 17'($urandom); end
      if (it % 4 == 2) begin cr = '0; mr = mr & 17'($urandom); end
      if (it % 4 == 3) begin cm = '1; mm = mm | 17'($urandom); pr = pr & 16'($urandom); end
      if (it % 8 == 7) begin pr = '0; mr = '0; end
      wr(3'd0, {29'b0, cm}); wr(3'd1, {15'b0, mm});
      wr(3'd2, {16'b0, pm}); wr(3'd3, pp);
      critReq = cr; mainReq = mr; periReq = pr;
      tick();
      e = model(cm, mm, pm, pp, cr, mr, pr);
      rd(3'd4, d); chk("R2/R3/R4/R5/R6/R7/R8 status", d, e);
      chk("R9 irq", {31'b0, irqOut}, {31'b0, |e[26:24]});
      if (it % 16 == 0) begin
        rd(3'd1, d); chk("R10 mainMask readback", d, {15'b0, mm});
      end
    end

    summary();
    $finish;
  end
endmodule